// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets an on-chip requester read and write an external asynchronous static RAM of 131,072 words by 24 bits. The requester uses a valid/ready handshake. With each request it supplies a 17-bit word address, 24 bits of write data and a write flag. Read results come back on a data register with a one-cycle valid strobe. On the memory side the block drives the address, three chip selects of mixed polarity, an output enable, a write enable and a shared 24-bit tri-state data bus.

The memory has no clock, so every timing limit it imposes has to be met by counting controller clock cycles. Two parameters give the controller clock period in picoseconds and the memory speed grade in nanoseconds. From these, constant functions derive three counts: the read access length, the write-enable low time and the data setup time. Each count is the limit divided by the clock period and rounded up, and none is ever less than one cycle.

A read holds output enable low for the whole access and registers the bus in the last counted cycle. A write keeps output enable high throughout. It lowers write enable one cycle after selecting the chip, leaves the bus undriven for one turnaround cycle, and then drives the data until the cycle after write enable has risen again. Each access is followed by one deselected recovery cycle before the next request is taken.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0, the chip is deselected (`mem_sel_a_n`=1, `mem_sel_b_n`=1, `mem_sel_c`=0), and `mem_oe_n` and `mem_we_n` are both 1.
- R2: The chip is selected (`mem_sel_a_n`=0, `mem_sel_b_n`=0, `mem_sel_c`=1) only while an access is in progress. In any cycle where `req_ready` is 1, the chip is deselected.
- R3: A read keeps `mem_we_n` high and `mem_oe_n` low for N_AA cycles, where N_AA = ceil(tAA / clock period) with a minimum of 1. The bus is registered at the end of the last of these cycles, and `rsp_valid` is a single-cycle pulse that rises at clock edge acc+N_AA, where acc is the edge that accepted the request.
- R4: Throughout a write, `mem_oe_n` stays high and `mem_addr` stays at the accepted address.
- R5: The controller never drives the bus while `mem_oe_n` is low. It also leaves the bus undriven in the first cycle that `mem_we_n` is low, and stops driving in the cycle after `mem_we_n` returns high.
- R6: `mem_we_n` is low for exactly N_WLOW = max(ceil(tPWE), 1 + ceil(tSD), ceil(tAW) - 1) consecutive cycles. The committed write data is on the bus for at least ceil(tSD) of those cycles, ending at the rising edge of `mem_we_n`.
- R7: `req_ready` falls after an accepted request and rises again only after one deselected recovery cycle. With `req_valid` held high, consecutive reads are accepted N_AA+2 edges apart and consecutive writes N_WLOW+4 edges apart.
- R8: A read returns the 24-bit word most recently written to the same address. This holds for all-zero, all-one and alternating data patterns and at addresses 0 and 2^17-1.
- R9: The timing limits per speed grade are: 8 ns gives tAA 8, tPWE 6, tSD 4.5, tAW 7; 9 ns gives 9, 8, 5, 8; 10 ns gives 10, 8, 5, 8; 12 ns gives 12, 9, 5, 9 (all in ns). At the default 20 ns clock with grade 10, N_AA is 1 and N_WLOW is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 24 | Write data |
| rsp_data | output | 24 | Registered read data |
| rsp_valid | output | 1 | One-cycle strobe marking new `rsp_data` |
| mem_addr | output | 17 | Memory address pins |
| mem_sel_a_n | output | 1 | Active-low chip select, first |
| mem_sel_b_n | output | 1 | Active-low chip select, second |
| mem_sel_c | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq | inout | 24 | Bidirectional memory data bus |

## Verification
In the last cycle of a read, one clock edge does two things: it registers the word the memory is driving, and it moves the controller into recovery, which deselects the chip and raises output enable. To provoke this, back-to-back reads with `req_valid` held high are issued to adjacent addresses that hold different patterns. The memory model stops driving the moment output enable rises, so a capture taken one edge late, or with the wrong address, returns the wrong word. The check compares both returned words with the scoreboard and measures the acceptance spacing against N_AA+2.

// File: rtl/sac_pkg.sv
package sac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSET,
    ST_WLOW,
    ST_WEND,
    ST_REC
  } sac_state_e;

  // Address-to-data time in ps for a speed grade (ns)
  function automatic int taa_ps(input int grade);
    case (grade)
      8:       return 8000;
      9:       return 9000;
      12:      return 12000;
      default: return 10000;
    endcase
  endfunction

  // Minimum write-enable low time with output enable held high
  function automatic int tpwe_ps(input int grade);
    case (grade)
      8:       return 6000;
      12:      return 9000;
      default: return 8000;
    endcase
  endfunction

  // Data setup before the write-ending edge
  function automatic int tsd_ps(input int grade);
    return (grade == 8) ? 4500 : 5000;
  endfunction

  // Address setup before the write-ending edge
  function automatic int taw_ps(input int grade);
    case (grade)
      8:       return 7000;
      12:      return 9000;
      default: return 8000;
    endcase
  endfunction

  // Round a time up to whole clock cycles, never below one
  function automatic int cyc_up(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  // Write-enable low length: pulse width, turnaround plus setup, address setup
  function automatic int wlow_cycles(input int grade, input int clk_ps);
    int a;
    int b;
    int c;
    a = cyc_up(tpwe_ps(grade), clk_ps);
    b = 1 + cyc_up(tsd_ps(grade), clk_ps);
    c = cyc_up(taw_ps(grade), clk_ps) - 1;
    if (b > a) a = b;
    if (c > a) a = c;
    return a;
  endfunction

endpackage

// File: rtl/sac_phase_timer.sv
module sac_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             last
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val - CNT_W'(1);
    end else if (count != '0) begin
      count <= count - CNT_W'(1);
    end
  end

  assign last = (count == '0);

endmodule

// File: rtl/sac_sequencer.sv
module sac_sequencer
  import sac_pkg::*;
#(
  parameter int N_AA   = 1,
  parameter int N_WLOW = 2,
  parameter int CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             t_last,
  input  logic [CNT_W-1:0] t_count,
  output sac_state_e       st,
  output logic             req_ready,
  output logic             accept,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  output logic             cap_fire,
  output logic             wr_turn
);

  sac_state_e nxt;

  always_comb begin
    nxt      = st;
    accept   = 1'b0;
    t_load   = 1'b0;
    t_val    = '0;
    cap_fire = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            nxt = ST_WSET;
          end else begin
            nxt    = ST_READ;
            t_load = 1'b1;
            t_val  = CNT_W'(N_AA);
          end
        end
      end
      ST_READ: begin
        if (t_last) begin
          cap_fire = 1'b1;
          nxt      = ST_REC;
        end
      end
      ST_WSET: begin
        nxt    = ST_WLOW;
        t_load = 1'b1;
        t_val  = CNT_W'(N_WLOW);
      end
      ST_WLOW: if (t_last) nxt = ST_WEND;
      ST_WEND: nxt = ST_REC;
      ST_REC:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign req_ready = (st == ST_IDLE);
  assign wr_turn   = (st == ST_WLOW) && (t_count == CNT_W'(N_WLOW - 1));

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R7

endmodule

// File: rtl/sac_pin_drive.sv
module sac_pin_drive
  import sac_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sac_state_e    st,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cap_fire,
  input  logic          wr_turn,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] mem_addr,
  output logic          sel_a_n,
  output logic          sel_b_n,
  output logic          sel_c,
  output logic          oe_n,
  output logic          we_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_valid
);

  logic [DW-1:0] wdata_q;
  logic          chip_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      wdata_q   <= '0;
      rsp_data  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        wdata_q  <= req_wdata;
      end
      if (cap_fire) rsp_data <= dq_in;
      rsp_valid <= cap_fire;
    end
  end

  assign chip_on = (st == ST_READ) || (st == ST_WSET) ||
                   (st == ST_WLOW) || (st == ST_WEND);
  assign sel_a_n = !chip_on;
  assign sel_b_n = !chip_on;
  assign sel_c   = chip_on;
  assign oe_n    = (st != ST_READ);
  assign we_n    = (st != ST_WLOW);
  assign dq_oe   = ((st == ST_WLOW) && !wr_turn) || (st == ST_WEND);
  assign dq_out  = wdata_q;

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(mem_addr)); // R4
  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe); // R5
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> !dq_oe); // R5
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |=> !dq_oe); // R5
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sac_pkg::*;
#(
  parameter int CLK_PS   = 20000,
  parameter int GRADE_NS = 10,
  parameter int AW       = 17,
  parameter int DW       = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_a_n,
  output logic          mem_sel_b_n,
  output logic          mem_sel_c,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  inout  wire  [DW-1:0] mem_dq
);

  localparam int N_AA   = cyc_up(taa_ps(GRADE_NS), CLK_PS);
  localparam int N_WLOW = wlow_cycles(GRADE_NS, CLK_PS);
  localparam int N_MAX  = (N_AA > N_WLOW) ? N_AA : N_WLOW;
  localparam int CNT_W  = $clog2(N_MAX + 1);

  sac_state_e       st;
  logic             accept;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic [CNT_W-1:0] t_count;
  logic             t_last;
  logic             cap_fire;
  logic             wr_turn;
  logic [DW-1:0]    dq_out;
  logic             dq_oe;
  logic [DW-1:0]    dq_in;

  sac_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .count    (t_count),
    .last     (t_last)
  );

  sac_sequencer #(.N_AA(N_AA), .N_WLOW(N_WLOW), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .t_last    (t_last),
    .t_count   (t_count),
    .st        (st),
    .req_ready (req_ready),
    .accept    (accept),
    .t_load    (t_load),
    .t_val     (t_val),
    .cap_fire  (cap_fire),
    .wr_turn   (wr_turn)
  );

  sac_pin_drive #(.AW(AW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cap_fire  (cap_fire),
    .wr_turn   (wr_turn),
    .dq_in     (dq_in),
    .mem_addr  (mem_addr),
    .sel_a_n   (mem_sel_a_n),
    .sel_b_n   (mem_sel_b_n),
    .sel_c     (mem_sel_c),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .rsp_data  (rsp_data),
    .rsp_valid (rsp_valid)
  );

  assign mem_dq = dq_oe ? dq_out : 'z;
  assign dq_in  = mem_dq;

  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_a_n && mem_sel_b_n && !mem_sel_c)); // R2

endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

  localparam int TCK_PS = 20000;
  localparam int GRADE  = 10;

  // Bench restatement of the timing table (R9), in ns*10
  function automatic int lim_x10(input int g, input int which);
    int t[4];
    case (g)
      8:       t = '{80, 60, 45, 70};
      9:       t = '{90, 80, 50, 80};
      12:      t = '{120, 90, 50, 90};
      default: t = '{100, 80, 50, 80};
    endcase
    return t[which];
  endfunction
  function automatic int to_cyc(input int x10);
    int n;
    n = 0;
    while (n * TCK_PS < x10 * 100) n++;
    return (n == 0) ? 1 : n;
  endfunction

  localparam int E_AA = to_cyc(lim_x10(GRADE, 0));
  localparam int E_SD = to_cyc(lim_x10(GRADE, 2));
  localparam int E_PW = to_cyc(lim_x10(GRADE, 1));
  localparam int E_AW = to_cyc(lim_x10(GRADE, 3));
  localparam int E_WL = (E_PW >= E_SD + 1 && E_PW >= E_AW - 1) ? E_PW :
                        ((E_SD + 1 >= E_AW - 1) ? E_SD + 1 : E_AW - 1);

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_write = 0;
  logic [16:0] req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic        req_ready;
  logic [23:0] rsp_data;
  logic        rsp_valid;
  logic [16:0] mem_addr;
  logic        mem_sel_a_n, mem_sel_b_n, mem_sel_c, mem_oe_n, mem_we_n;
  wire  [23:0] mem_dq;

  always #10 clk = ~clk;

  sram_async_ctrl #(.CLK_PS(TCK_PS), .GRADE_NS(GRADE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .mem_addr(mem_addr),
    .mem_sel_a_n(mem_sel_a_n), .mem_sel_b_n(mem_sel_b_n), .mem_sel_c(mem_sel_c),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [23:0] mdl[int];
  logic [23:0] sb[int];
  logic [23:0] rq[$];
  int          rcq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mdl_peek(input logic [16:0] a);
    return mdl.exists(int'(a)) ? mdl[int'(a)] : 24'h0;
  endfunction

  // Behavioural memory: drives on read, checks write windows
  wire        msel = !mem_sel_a_n && !mem_sel_b_n && mem_sel_c;
  wire        mdrv = msel && !mem_oe_n && mem_we_n;
  wire [23:0] mval = mdl_peek(mem_addr);
  assign mem_dq = mdrv ? mval : 'z;

  always @(posedge clk) cyc <= cyc + 1;

  bit          in_win = 0;
  int          wlen, stab;
  logic [16:0] waddr;
  logic [23:0] lastv;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin rq.push_back(rsp_data); rcq.push_back(cyc); end
      if (req_ready && msel) check(0, "R2 selected while ready", 1, 0);
      if (msel && !mem_we_n) begin
        if (!in_win) begin in_win = 1; wlen = 0; stab = 0; waddr = mem_addr; end
        wlen++;
        if (mem_addr !== waddr) check(0, "R4 address moved", int'(mem_addr), int'(waddr));
        if (!mem_oe_n) check(0, "R4 oe low in write", 0, 1);
        if (wlen > 1 && mem_dq == lastv) stab++; else stab = 1;
        lastv = mem_dq;
      end else if (in_win) begin
        in_win = 0;
        check(wlen == E_WL, "R6 we low length", wlen, E_WL);
        check(stab >= E_SD, "R6 data setup cycles", stab, E_SD);
        mdl[int'(waddr)] = lastv;
      end
    end
  end

  // Issue one request; returns the accepting edge number
  task automatic issue(input bit w, input logic [16:0] a, input logic [23:0] d,
                       output int acc);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [23:0] d, input string req);
    int acc;
    issue(1, a, d, acc);
    sb[int'(a)] = d;
    wait_idle();
    check(mdl_peek(a) == d, req, int'(mdl_peek(a)), int'(d));
  endtask

  task automatic do_read(input logic [16:0] a, input string req);
    int acc, guard;
    logic [23:0] got;
    int gcyc;
    issue(0, a, 24'h0, acc);
    guard = 0;
    while (rq.size() == 0 && guard < 50) begin @(posedge clk); guard++; end
    if (rq.size() == 0) begin check(0, "R3 no rsp_valid", 0, 1); return; end
    got = rq.pop_front(); gcyc = rcq.pop_front();
    check(gcyc - acc == E_AA, "R3 read latency", gcyc - acc, E_AA);
    check(got == sb[int'(a)], req, int'(got), int'(sb[int'(a)]));
    wait_idle();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid, "R1 ready/valid in reset", {req_ready, rsp_valid}, 2);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1 ready after reset", req_ready, 1);
    check(rsp_valid == 0, "R1 rsp_valid after reset", rsp_valid, 0);
    check({mem_sel_a_n, mem_sel_b_n, mem_sel_c} == 3'b110, "R1 deselected",
          {mem_sel_a_n, mem_sel_b_n, mem_sel_c}, 3'b110);
    check(mem_oe_n && mem_we_n, "R1 oe/we idle", {mem_oe_n, mem_we_n}, 3);
  endtask

  task automatic t_patterns();
    do_write(17'h00000, 24'h000000, "R8 write zeros");
    do_write(17'h1FFFF, 24'hFFFFFF, "R8 write ones top addr");
    do_write(17'h00001, 24'hAAAAAA, "R8 write alt");
    do_write(17'h00002, 24'h555555, "R8 write alt inv");
    do_read(17'h00000, "R8 read zeros");
    do_read(17'h1FFFF, "R8 read ones top addr");
    do_read(17'h00001, "R8 read alt");
    do_read(17'h00002, "R8 read alt inv");
    do_write(17'h00001, 24'h123456, "R8 overwrite");
    do_read(17'h00001, "R8 read overwrite");
  endtask

  task automatic t_read_shape();
    int acc, lo_oe;
    issue(0, 17'h1FFFF, 24'h0, acc);
    lo_oe = 0;
    while (!req_ready) begin
      if (!mem_oe_n) begin
        lo_oe++;
        if (!mem_we_n) check(0, "R3 we low during read", 0, 1);
      end
      @(negedge clk);
    end
    check(lo_oe == E_AA, "R3 oe low cycles", lo_oe, E_AA);
    void'(rq.pop_front()); void'(rcq.pop_front());
  endtask

  task automatic t_b2b_reads();
    int e1, e2;
    logic [23:0] g1, g2;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 17'h00001;
    while (!req_ready) @(negedge clk);
    e1 = cyc + 1;
    @(negedge clk);
    req_addr = 17'h00002;
    while (!req_ready) @(negedge clk);
    e2 = cyc + 1;
    @(negedge clk);
    req_valid = 0;
    wait_idle();
    repeat (2) @(negedge clk);
    check(e2 - e1 == E_AA + 2, "R7 read spacing", e2 - e1, E_AA + 2);
    check(rq.size() == 2, "R3 two responses", rq.size(), 2);
    if (rq.size() == 2) begin
      g1 = rq.pop_front(); g2 = rq.pop_front();
      check(g1 == sb[1], "R8 b2b first word", int'(g1), int'(sb[1]));
      check(g2 == sb[2], "R8 b2b second word", int'(g2), int'(sb[2]));
    end
    rq.delete(); rcq.delete();
  endtask

  task automatic t_b2b_writes();
    int e1, e2;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 17'h00010; req_wdata = 24'h0F0F0F;
    while (!req_ready) @(negedge clk);
    e1 = cyc + 1;
    sb[16] = 24'h0F0F0F;
    @(negedge clk);
    req_addr = 17'h00011; req_wdata = 24'hF0F0F0;
    while (!req_ready) @(negedge clk);
    e2 = cyc + 1;
    sb[17] = 24'hF0F0F0;
    @(negedge clk);
    req_valid = 0;
    wait_idle();
    repeat (2) @(negedge clk);
    check(e2 - e1 == E_WL + 4, "R7 write spacing", e2 - e1, E_WL + 4);
    check(mdl_peek(17'h10) == 24'h0F0F0F, "R6 b2b write 1", int'(mdl_peek(17'h10)), 24'h0F0F0F);
    check(mdl_peek(17'h11) == 24'hF0F0F0, "R6 b2b write 2", int'(mdl_peek(17'h11)), 24'hF0F0F0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic [16:0] a;
      a = ($urandom % 4 == 0) ? 17'h1FFF8 + 17'($urandom % 8) : 17'($urandom % 8);
      if (($urandom % 2 == 0) || !sb.exists(int'(a))) do_write(a, 24'($urandom), "R8 random write");
      else do_read(a, "R8 random read");
    end
  endtask

  initial begin
    check(E_AA == 1 && E_WL == 2, "R9 derived counts", E_AA * 16 + E_WL, 18);
    t_reset();
    t_patterns();
    t_read_shape();
    t_b2b_reads();
    t_b2b_writes();
    t_random();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule